// File: doc/BRIEF.md
# Serial Camera Line-Capture Deserializer

This block takes pixel data from an image sensor that drives one serial data wire, together with a horizontal-sync (line-valid) wire and a pixel clock. None of these three inputs is related to the system clock, so each one passes through a synchroniser before it is used. A small capture sequencer walks a fixed handshake. It waits for line-valid, then waits for the pixel clock to go high and takes one data bit, then waits for the pixel clock to go low. It then starts again from the line-valid wait.

Bits are packed into bytes, with the earliest bit ending up in the most significant position. Each completed byte goes into an eight-entry receive queue without any request from outside. The queue's read side is a valid/ready byte stream. The block also reports the fill level, empty and full, and a sticky overflow flag. When the queue is full at the moment a byte completes, capture stalls. The completed byte is held until a slot frees.

Top module: `linecap_deser`

## Requirements
- R1: After synchronous reset the queue is empty: `fifo_empty`=1, `fifo_full`=0, `fill_level`=0, `out_valid`=0 and `ovf_flag`=0.
- R2: While line-valid is high, each high phase of the pixel clock yields exactly one bit. Eight such bits form one byte, and the first bit received lands in bit 7.
- R3: A pixel-clock high phase seen while line-valid is low contributes no bit.
- R4: `out_valid` equals the inverse of `fifo_empty`. `out_data` shows the oldest byte and holds steady until a cycle where `out_valid` and `out_ready` are both high removes it. Bytes leave in the order they were completed.
- R5: `fill_level` changes by at most one per cycle. `fifo_empty` is high exactly when `fill_level` is 0. Once the inputs are quiet, `fill_level` equals the number of captured bits divided by 8, less the bytes already read.
- R6: If a byte completes while the queue is full, capture stalls. The byte is kept and pushed as soon as a slot frees. Pixel-clock phases that occur during the stall are dropped.
- R7: `ovf_flag` rises when a completed byte meets a full queue. It stays high until a cycle with `ovf_clr` high; if a new overflow happens in that same cycle, it stays set.
- R8: While `en` is low the sequencer returns to the line-valid wait and discards any partial byte, including a stalled one.
- R9: The queue holds 8 bytes. `fifo_full` is high exactly when `fill_level` is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable, synchronous |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| line_valid_in | input | 1 | Sensor horizontal-sync / line-valid, asynchronous |
| pix_clk_in | input | 1 | Sensor pixel clock, asynchronous |
| pix_dat_in | input | 1 | Sensor serial data bit, asynchronous |
| out_data | output | 8 | Oldest queued byte |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Consumer accepts the byte |
| fill_level | output | 4 | Number of queued bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| fifo_full | output | 1 | Queue holds 8 bytes |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest state to reach is the stall. It needs a ninth byte to complete while eight unread bytes sit in the queue. Further pixel-clock phases must then arrive while that byte is held, and these must disappear without trace. The bench holds `out_ready` low and streams nine bytes on one line, followed by one more byte that must be dropped. It then clears the flag and drains the queue. The reference queue inside the bench predicts that the held ninth byte appears right after the original eight, and that the dropped bits never show up.

// File: rtl/linecap_pkg.sv
package linecap_pkg;

    localparam int BYTE_W     = 8;
    localparam int QUEUE_SLOTS = 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        CS_WAIT_LINE = 2'd0,
        CS_WAIT_HIGH = 2'd1,
        CS_WAIT_LOW  = 2'd2,
        CS_HOLD      = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic lv;
        logic pclk;
        logic dat;
    } sens_t;

    localparam int SENS_W = $bits(sens_t);

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                   input logic bit_in);
        return {cur[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/linecap_sync.sv
module linecap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/linecap_fifo.sv
module linecap_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    output logic [WIDTH-1:0]           head_data,
    output logic                       head_valid,
    input  logic                       head_ready,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_pop, do_push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign empty      = (level == '0);
    assign full       = (level == LW'(DEPTH));
    assign head_valid = !empty;
    assign head_data  = mem[rd_ptr];
    assign do_pop     = head_valid && head_ready;
    assign do_push    = push && !full;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    // R5: the fill level never jumps by more than one
    a_r5_level_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level == $past(level) || level == $past(level) + LW'(1)
                  || level == $past(level) - LW'(1)));

    // R4: an unaccepted head byte stays put
    a_r4_head_hold: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !head_ready) |=> (head_valid && $stable(head_data)));

    // R9: level never exceeds the depth
    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));
endmodule

// File: rtl/linecap_seq.sv
module linecap_seq
    import linecap_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            ovf_clr,
    input  sens_t           sens,
    input  logic            fifo_full,
    output logic            push,
    output logic [BITS-1:0] push_data,
    output logic            ovf
);
    localparam int CW = $clog2(BITS);

    cap_state_e      state;
    logic [BITS-1:0] shreg;
    logic [CW-1:0]   cnt;
    logic            take, last_bit, ovf_set;
    logic [BITS-1:0] next_shreg;

    assign take       = en && (state == CS_WAIT_HIGH) && sens.lv && sens.pclk;
    assign last_bit   = (cnt == CW'(BITS-1));
    assign next_shreg = {shreg[BITS-2:0], sens.dat};
    assign ovf_set    = take && last_bit && fifo_full;
    assign push       = !fifo_full &&
                        ((take && last_bit) || (en && state == CS_HOLD));
    assign push_data  = (state == CS_HOLD) ? shreg : next_shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= CS_WAIT_LINE;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                CS_WAIT_LINE: if (sens.lv) state <= CS_WAIT_HIGH;
                CS_WAIT_HIGH: begin
                    if (!sens.lv) begin
                        state <= CS_WAIT_LINE;
                    end else if (sens.pclk) begin
                        if (last_bit) begin
                            cnt <= '0;
                            if (fifo_full) begin
                                shreg <= next_shreg;
                                state <= CS_HOLD;
                            end else begin
                                shreg <= '0;
                                state <= CS_WAIT_LOW;
                            end
                        end else begin
                            shreg <= next_shreg;
                            cnt   <= cnt + CW'(1);
                            state <= CS_WAIT_LOW;
                        end
                    end
                end
                CS_WAIT_LOW: if (!sens.pclk) state <= CS_WAIT_LINE;
                CS_HOLD: if (!fifo_full) begin
                    shreg <= '0;
                    state <= CS_WAIT_LOW;
                end
                default: state <= CS_WAIT_LINE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // R7: overflow is sticky until cleared
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    // R8: disabling returns to the line wait with an empty bit count
    a_r8_disable_reset: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == CS_WAIT_LINE && cnt == '0));

    // R6: a held byte is frozen while the queue stays full
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (en && state == CS_HOLD && fifo_full) |=> (state == CS_HOLD && $stable(shreg)));
endmodule

// File: rtl/linecap_deser.sv
module linecap_deser
    import linecap_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int DEPTH  = QUEUE_SLOTS,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       ovf_clr,
    input  logic                       line_valid_in,
    input  logic                       pix_clk_in,
    input  logic                       pix_dat_in,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       fifo_empty,
    output logic                       fifo_full,
    output logic                       ovf_flag
);
    sens_t              raw, synced;
    logic               push;
    logic [DATA_W-1:0]  push_data;

    assign raw = '{lv: line_valid_in, pclk: pix_clk_in, dat: pix_dat_in};

    linecap_sync #(.WIDTH(SENS_W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw),
        .sync_out (synced)
    );

    linecap_seq #(.BITS(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ovf_clr   (ovf_clr),
        .sens      (synced),
        .fifo_full (fifo_full),
        .push      (push),
        .push_data (push_data),
        .ovf       (ovf_flag)
    );

    linecap_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (push_data),
        .head_data  (out_data),
        .head_valid (out_valid),
        .head_ready (out_ready),
        .level      (fill_level),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    // R6: the sequencer never offers a byte to a full queue
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);
endmodule

// File: tb/linecap_deser_test.sv
`timescale 1ns/1ps
module linecap_deser_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, ovf_clr = 1'b0;
    logic       lv = 1'b0, pclk = 1'b0, dat = 1'b0;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, fifo_empty, fifo_full, ovf_flag;
    logic [3:0] fill_level;

    int total = 0, bad = 0, cycles = 0;
    logic [7:0] mq[$];
    logic [7:0] acc = '0;
    int         nb = 0;
    logic       pend_v = 1'b0;
    logic [7:0] pend = '0;

    always #5 clk = ~clk;

    linecap_deser uut (
        .clk(clk), .rst(rst), .en(en), .ovf_clr(ovf_clr),
        .line_valid_in(lv), .pix_clk_in(pclk), .pix_dat_in(dat),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .fill_level(fill_level), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .ovf_flag(ovf_flag)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // reference model: one bit per high phase while line-valid is high
    task automatic model_bit(input logic b);
        if (!lv || !en || pend_v) return;
        acc = {acc[6:0], b};
        nb++;
        if (nb == 8) begin
            nb = 0;
            if (mq.size() < 8) mq.push_back(acc);
            else begin pend_v = 1'b1; pend = acc; end
        end
    endtask

    task automatic send_bit(input logic b);
        model_bit(b);
        dat = b; pclk = 1'b0;
        repeat (4) @(negedge clk);
        pclk = 1'b1;
        repeat (4) @(negedge clk);
        pclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic line_on();
        lv = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic line_off();
        pclk = 1'b0; repeat (4) @(negedge clk);
        lv = 1'b0; repeat (6) @(negedge clk);
    endtask

    task automatic drain();
        out_ready = 1'b1; repeat (30) @(negedge clk);
        out_ready = 1'b0; @(negedge clk);
    endtask

    // per-cycle comparison against the reference queue
    always @(negedge clk) begin
        #4;
        if (!rst) begin
            chk(out_valid == !fifo_empty, "R4 valid/empty", out_valid, !fifo_empty);
            chk(fifo_empty == (fill_level == 0), "R5 empty/level", fill_level, 0);
            chk(fifo_full == (fill_level == 8), "R9 full/level", fill_level, 8);
            if (out_valid && out_ready) begin
                if (mq.size() == 0) chk(1'b0, "R4 unexpected byte", out_data, 0);
                else begin
                    chk(out_data == mq[0], "R2 R4 byte order/value", out_data, mq[0]);
                    void'(mq.pop_front());
                    if (pend_v) begin mq.push_back(pend); pend_v = 1'b0; end
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                chk(1'b0, "watchdog", cycles, 100000);
                finish_up();
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
        chk(fill_level == 0, "R1 level", fill_level, 0);
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);

        // R2: two bytes on one line, MSB first
        line_on(); send_byte(8'hA5); send_byte(8'h3C); line_off();
        chk(fill_level == 2, "R2 R5 level after 16 bits", fill_level, 2);
        drain();
        chk(fill_level == 0, "R5 level after drain", fill_level, 0);

        // R3: pixel clocks with line-valid low
        send_byte(8'hFF);
        repeat (6) @(negedge clk);
        chk(fill_level == 0, "R3 no bits while line low", fill_level, 0);
        line_on(); send_bit(1); send_bit(0); send_bit(1); send_bit(1); line_off();
        send_bit(0); send_bit(0); send_bit(1); send_bit(0);
        line_on(); send_bit(0); send_bit(1); send_bit(1); send_bit(0); line_off();
        chk(fill_level == 1, "R3 byte from line-high bits only", fill_level, 1);
        chk(out_data == 8'hB6, "R3 R2 split byte value", out_data, 8'hB6);
        drain();

        // R6 R7 R9: overflow and stall
        line_on();
        for (int k = 0; k < 9; k++) send_byte(8'(k * 17 + 1));
        line_off();
        chk(fill_level == 8, "R9 level at depth", fill_level, 8);
        chk(fifo_full == 1'b1, "R9 full", fifo_full, 1);
        chk(ovf_flag == 1'b1, "R7 overflow set", ovf_flag, 1);
        line_on(); send_byte(8'hFF); line_off();
        chk(fill_level == 8, "R6 bits dropped while stalled", fill_level, 8);
        repeat (20) @(negedge clk);
        chk(ovf_flag == 1'b1, "R7 overflow sticky", ovf_flag, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
        chk(ovf_flag == 1'b0, "R7 overflow cleared", ovf_flag, 0);
        drain();
        chk(fill_level == 0, "R6 held byte pushed then drained", fill_level, 0);
        chk(mq.size() == 0, "R6 model queue consumed", mq.size(), 0);

        // R8: disable discards partial byte
        line_on(); send_bit(1); send_bit(1); send_bit(1); line_off();
        en = 1'b0; acc = '0; nb = 0; pend_v = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1; @(negedge clk);
        line_on(); send_byte(8'h5A); line_off();
        chk(fill_level == 1, "R8 one byte after re-enable", fill_level, 1);
        chk(out_data == 8'h5A, "R8 partial bits discarded", out_data, 8'h5A);
        drain();
        chk(fifo_empty == 1'b1, "R5 empty at end", fifo_empty, 1);

        finish_up();
    end
endmodule